// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a 16-bit successive-approximation converter with a three-wire serial port. A start request lowers an active-low chip select. The block then drives a serial clock in mode 0 from the system clock: the clock idles low and each data bit is taken on its rising edge. Exactly 24 serial clocks make up one frame.

The first eight bits of a frame are a padding field that the converter always sends as zeros. The block checks them and keeps a sticky error flag if any of them reads as one. The last sixteen bits, most significant first, form the result. The result is published together with a one-cycle valid pulse. After the frame, chip select rises and is held high for a minimum gap. This gap lets the converter shut down and reset before the next frame. A repeat input chains frames back to back, and an abort input ends a frame at once.

An optional channel-select output for an external input multiplexer steps forward just after the sixth falling clock edge of every frame. The next channel then has the rest of the frame to settle.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and right after it, cs_n_o is 1, sclk_o is 0, and busy_o, valid_o, proto_err_o, result_o and mux_sel_o are all 0.
- R2: sclk_o is low whenever cs_n_o is high. A frame has exactly 24 rising edges of sclk_o. Every high phase and every low phase inside a frame lasts HALF_DIV system clocks.
- R3: The first rising edge of sclk_o comes exactly SETUP_CLKS system clocks after cs_n_o falls.
- R4: The sample on the n-th rising edge is frame bit 24-n. Frame bits 15..0 form result_o (bit 15 is sampled on rise 9, bit 0 on rise 24). valid_o is high for exactly one cycle. It rises together with the 24th rising edge of sclk_o, and result_o carries the new value in that same cycle.
- R5: On a completed frame, cs_n_o rises exactly HALF_DIV system clocks after the 24th falling edge of sclk_o, never earlier.
- R6: After cs_n_o rises, it stays high for at least GAP_CLKS system clocks. busy_o rises in the cycle after the accepted start request. It falls exactly GAP_CLKS clocks after cs_n_o rises when no further frame follows.
- R7: If repeat_i is high when the gap ends, the next frame starts without a start request. cs_n_o then falls exactly GAP_CLKS clocks after it rose.
- R8: proto_err_o is set if any of the eight padding bits (frame bits 23..16, samples 1 to 8) reads as 1. Ones in the data bits do not set it. Once set, it is cleared only by reset.
- R9: mux_sel_o (2 bits, wrapping from 3 to 0) increments by exactly one per frame. It changes in the same cycle as the 6th falling edge of sclk_o.
- R10: When abort_i is high while cs_n_o is low, the next cycle has cs_n_o high and sclk_o low. No valid pulse follows, result_o keeps its old value, and busy_o falls GAP_CLKS clocks after cs_n_o rose.
- R11: A start request while busy_o is high is ignored: no extra frame and no extra valid pulse follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one frame (taken when idle) |
| abort_i | input | 1 | End the current frame immediately |
| repeat_i | input | 1 | Chain the next frame once the gap ends |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Chip select, active low |
| mux_sel_o | output | MUX_W | Channel select for an external input multiplexer |
| result_o | output | DATA_W | Last completed conversion result |
| valid_o | output | 1 | One-cycle pulse when result_o is updated |
| proto_err_o | output | 1 | Sticky flag: a padding bit read as one |
| busy_o | output | 1 | High from the start until the chip-select gap has elapsed |

## Verification
A sequencer stuck in the wrong phase shows up at the ports within one half period of the serial clock. It appears as a stretched or shortened phase, a missing or extra edge, or chip select moving at the wrong time. A bit counter that is off by one misaligns every result on the next frame and moves the multiplexer step away from the sixth falling edge. A wrong padding check flips the error flag within the frame that triggers it. A broken abort path is visible one cycle after abort, through chip select, the clock and the valid pulse.

// File: rtl/afr_pkg.sv
package afr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } afr_state_e;

  // Reload value for a phase that must last len system clocks.
  function automatic int unsigned afr_reload(input int unsigned len);
    return (len == 0) ? 0 : len - 1;
  endfunction

  function automatic int unsigned afr_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // True while the sample index falls inside the padding field.
  function automatic logic afr_in_pad(input int unsigned idx,
                                      input int unsigned pad_w);
    return idx < pad_w;
  endfunction

endpackage

// File: rtl/afr_timer.sv
module afr_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/afr_capture.sv
module afr_capture
  import afr_pkg::*;
#(
  parameter int PAD_W  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              pad_err_o
);
  localparam int FRAME_W = PAD_W + DATA_W;

  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q   <= '0;
      cnt_q     <= '0;
      result_o  <= '0;
      valid_o   <= 1'b0;
      pad_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (sample_i) begin
        shift_q <= {shift_q[DATA_W-2:0], miso_i};
        cnt_q   <= cnt_q + 1'b1;
        if (afr_in_pad(int'(cnt_q), PAD_W) && miso_i)
          pad_err_o <= 1'b1;
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          result_o <= {shift_q[DATA_W-2:0], miso_i};
          valid_o  <= 1'b1;
        end
      end
    end
  end

  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/afr_mux_step.sv
module afr_mux_step #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] sel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_o <= '0;
    else if (step_i) sel_o <= sel_o + 1'b1;
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import afr_pkg::*;
#(
  parameter int HALF_DIV   = 6,
  parameter int SETUP_CLKS = 5,
  parameter int GAP_CLKS   = 3,
  parameter int PAD_W      = 8,
  parameter int DATA_W     = 16,
  parameter int MUX_W      = 2,
  parameter int MUX_EDGE   = 6,
  parameter bit MUX_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              repeat_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic [MUX_W-1:0]  mux_sel_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              proto_err_o,
  output logic              busy_o
);
  localparam int FRAME_W  = PAD_W + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int TMR_MAX  = afr_max3(HALF_DIV, SETUP_CLKS, GAP_CLKS);
  localparam int TMR_W    = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX);
  localparam logic [TMR_W-1:0] RL_HALF  = TMR_W'(afr_reload(HALF_DIV));
  localparam logic [TMR_W-1:0] RL_SETUP = TMR_W'(afr_reload(SETUP_CLKS));
  localparam logic [TMR_W-1:0] RL_GAP   = TMR_W'(afr_reload(GAP_CLKS));

  afr_state_e       state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  logic [CNT_W-1:0] bit_cnt;

  // Named internal events, also watched by the checker.
  logic frame_full, rise_ev, fall_ev, frame_go, step_now, active;

  assign active     = (state_q == ST_SETUP) || (state_q == ST_HIGH) || (state_q == ST_LOW);
  assign frame_full = (bit_cnt == CNT_W'(FRAME_W));
  assign rise_ev    = tmr_done && !abort_i &&
                      ((state_q == ST_SETUP) || (state_q == ST_LOW && !frame_full));
  assign fall_ev    = tmr_done && !abort_i && (state_q == ST_HIGH);
  assign frame_go   = (state_q == ST_IDLE && start_i) ||
                      (state_q == ST_GAP && tmr_done && repeat_i);
  assign step_now   = fall_ev && (bit_cnt == CNT_W'(MUX_EDGE));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (active && abort_i) begin
      state_d  = ST_GAP;
      tmr_load = 1'b1;
      tmr_val  = RL_GAP;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = RL_SETUP;
        end
        ST_SETUP: if (tmr_done) begin
          state_d = ST_HIGH; tmr_load = 1'b1; tmr_val = RL_HALF;
        end
        ST_HIGH: if (tmr_done) begin
          state_d = ST_LOW; tmr_load = 1'b1; tmr_val = RL_HALF;
        end
        ST_LOW: if (tmr_done) begin
          tmr_load = 1'b1;
          if (frame_full) begin
            state_d = ST_GAP;  tmr_val = RL_GAP;
          end else begin
            state_d = ST_HIGH; tmr_val = RL_HALF;
          end
        end
        ST_GAP: if (tmr_done) begin
          if (repeat_i) begin
            state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = RL_SETUP;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_o  <= 1'b0;
      cs_n_o  <= 1'b1;
      busy_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_o  <= (state_d == ST_HIGH);
      cs_n_o  <= (state_d == ST_IDLE) || (state_d == ST_GAP);
      busy_o  <= (state_d != ST_IDLE);
    end
  end

  afr_timer #(.W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  afr_capture #(.PAD_W(PAD_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (frame_go),
    .sample_i  (rise_ev),
    .miso_i    (miso_i),
    .bit_cnt_o (bit_cnt),
    .result_o  (result_o),
    .valid_o   (valid_o),
    .pad_err_o (proto_err_o)
  );

  generate
    if (MUX_EN) begin : g_mux
      afr_mux_step #(.W(MUX_W)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_now),
        .sel_o  (mux_sel_o)
      );
    end else begin : g_nomux
      assign mux_sel_o = '0;
    end
  endgenerate
endmodule

// File: rtl/afr_checker.sv
module afr_checker #(
  parameter int MUX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             abort_i,
  input logic             sclk_o,
  input logic             cs_n_o,
  input logic             valid_o,
  input logic             proto_err_o,
  input logic             busy_o,
  input logic [MUX_W-1:0] mux_sel_o,
  input logic             frame_full,
  input logic             step_now
);
  p_clk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_valid_at_last_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sclk_o && frame_full));

  p_cs_rise_complete_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && !$past(abort_i)) |-> frame_full);

  p_busy_covers_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);

  p_mux_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_now |=> (mux_sel_o == MUX_W'($past(mux_sel_o) + 1'b1)));

  p_abort_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !cs_n_o) |=> (cs_n_o && !sclk_o && !valid_o));
endmodule

bind adc_frame_reader afr_checker #(.MUX_W(MUX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_i     (abort_i),
  .sclk_o      (sclk_o),
  .cs_n_o      (cs_n_o),
  .valid_o     (valid_o),
  .proto_err_o (proto_err_o),
  .busy_o      (busy_o),
  .mux_sel_o   (mux_sel_o),
  .frame_full  (frame_full),
  .step_now    (step_now)
);

// File: tb/adc_frame_reader_test.sv
module adc_frame_reader_test;
  localparam int HD = 2;
  localparam int SU = 3;
  localparam int GP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0, repeat_i = 1'b0;
  logic miso_i, sclk_o, cs_n_o, valid_o, proto_err_o, busy_o;
  logic [1:0]  mux_sel_o;
  logic [15:0] result_o;

  always #10 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(HD), .SETUP_CLKS(SU), .GAP_CLKS(GP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .repeat_i(repeat_i), .miso_i(miso_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
    .mux_sel_o(mux_sel_o), .result_o(result_o), .valid_o(valid_o),
    .proto_err_o(proto_err_o), .busy_o(busy_o)
  );

  // Converter model: bit 23 first, next bit after each falling edge.
  logic [23:0] frame_w = '0;
  int fall_cnt = 0;
  always @(negedge sclk_o or posedge cs_n_o)
    if (cs_n_o) fall_cnt <= 0; else fall_cnt <= fall_cnt + 1;
  assign miso_i = (!cs_n_o && fall_cnt < 24) ? frame_w[5'(23 - fall_cnt)] : 1'b0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always @(negedge clk)
    if (!finished && cyc > 150000) begin
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
      $finish;
    end

  // Port monitor, updated only by tick().
  int rises, falls, nvalid, nmux, viol;
  int t_csfall, t_csrise, t_rise1, t_rise24, t_fall6, t_fall24, t_valid, t_mux;
  int t_edge, t_busyfall, hi_min, lo_min, last_gap;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_busy = 1'b0;
  logic [1:0] p_mux = '0;

  task automatic mon_clear();
    rises = 0; falls = 0; nvalid = 0; nmux = 0; viol = 0;
    hi_min = 1000; lo_min = 1000; last_gap = -1;
    t_csfall = -1; t_csrise = -1; t_rise1 = -1; t_rise24 = -1;
    t_fall6 = -1; t_fall24 = -1; t_valid = -1; t_mux = -1; t_busyfall = -1;
  endtask

  task automatic tick();
    @(negedge clk);
    if (cs_n_o && !p_cs) t_csrise = cyc;
    if (!cs_n_o && p_cs) begin
      t_csfall = cyc;
      if (t_csrise >= 0) last_gap = cyc - t_csrise;
    end
    if (sclk_o && !p_sclk) begin
      rises++;
      if (rises == 1) t_rise1 = cyc;
      else if (cyc - t_edge < lo_min) lo_min = cyc - t_edge;
      if (rises == 24) t_rise24 = cyc;
      t_edge = cyc;
    end
    if (!sclk_o && p_sclk) begin
      falls++;
      if (cyc - t_edge < hi_min) hi_min = cyc - t_edge;
      if (falls == 6) t_fall6 = cyc;
      if (falls == 24) t_fall24 = cyc;
      t_edge = cyc;
    end
    if (valid_o) begin nvalid++; t_valid = cyc; end
    if (mux_sel_o != p_mux) begin nmux++; t_mux = cyc; end
    if (!busy_o && p_busy) t_busyfall = cyc;
    if (cs_n_o && sclk_o) viol++;
    p_cs = cs_n_o; p_sclk = sclk_o; p_busy = busy_o; p_mux = mux_sel_o;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) tick();
  endtask

  logic [1:0] exp_mux = '0;
  bit exp_err = 1'b0;

  task automatic run_frame(input logic [15:0] d, input logic [7:0] pad, input bit full);
    frame_w = {pad, d};
    mon_clear();
    pulse_start();
    wait_idle();
    exp_mux = exp_mux + 2'd1;
    if (pad != 8'h00) exp_err = 1'b1;
    check(result_o == d, "R4 result", int'(result_o), int'(d));
    check(nvalid == 1 && t_valid == t_rise24, "R4 valid timing", t_valid, t_rise24);
    check(mux_sel_o == exp_mux, "R9 mux value", int'(mux_sel_o), int'(exp_mux));
    check(proto_err_o == exp_err, "R8 pad flag", int'(proto_err_o), int'(exp_err));
    if (full) begin
      check(rises == 24 && falls == 24, "R2 edge count", rises, 24);
      check(hi_min == HD && lo_min == HD, "R2 phase length", hi_min * 100 + lo_min, HD * 101);
      check(viol == 0, "R2 clock idle while deselected", viol, 0);
      check(t_rise1 - t_csfall == SU, "R3 setup", t_rise1 - t_csfall, SU);
      check(t_csrise - t_fall24 == HD, "R5 select release", t_csrise - t_fall24, HD);
      check(t_busyfall - t_csrise == GP, "R6 gap", t_busyfall - t_csrise, GP);
      check(nmux == 1 && t_mux == t_fall6, "R9 step timing", t_mux, t_fall6);
    end
  endtask

  initial begin
    logic [15:0] lfsr;
    logic [15:0] prev;
    mon_clear();
    repeat (3) tick();
    check(cs_n_o && !sclk_o, "R1 select/clock at reset", {cs_n_o, sclk_o}, 2);
    check(!busy_o && !valid_o && !proto_err_o, "R1 flags at reset",
          {busy_o, valid_o, proto_err_o}, 0);
    check(result_o == 0 && mux_sel_o == 0, "R1 result/mux at reset",
          int'(result_o) + int'(mux_sel_o), 0);
    rst_n = 1'b1;
    tick();

    // Sweep: extremes, walking one, walking zero, pseudo-random codes.
    run_frame(16'h0000, 8'h00, 1'b1);
    run_frame(16'hFFFF, 8'h00, 1'b1);
    for (int k = 0; k < 16; k++) run_frame(16'(1 << k), 8'h00, 1'b1);
    for (int k = 0; k < 16; k++) run_frame(~16'(1 << k), 8'h00, 1'b1);
    lfsr = 16'hACE1;
    for (int k = 0; k < 8; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_frame(lfsr, 8'h00, 1'b1);
    end
    check(proto_err_o == 1'b0, "R8 data ones do not flag", int'(proto_err_o), 0);

    // R10 abort mid-frame.
    prev = result_o;
    frame_w = {8'h00, 16'h1234};
    mon_clear();
    pulse_start();
    while (rises < 10) tick();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    check(cs_n_o && !sclk_o, "R10 stop next cycle", {cs_n_o, sclk_o}, 2);
    wait_idle();
    exp_mux = exp_mux + 2'd1;
    check(nvalid == 0, "R10 no valid", nvalid, 0);
    check(result_o == prev, "R10 result kept", int'(result_o), int'(prev));
    check(t_busyfall - t_csrise == GP, "R10 gap after abort", t_busyfall - t_csrise, GP);
    check(mux_sel_o == exp_mux, "R10 mux after abort", int'(mux_sel_o), int'(exp_mux));
    run_frame(16'h5A3C, 8'h00, 1'b1);

    // R11 start while busy.
    frame_w = {8'h00, 16'h0F0F};
    mon_clear();
    pulse_start();
    while (rises < 12) tick();
    pulse_start();
    wait_idle();
    repeat (12) tick();
    exp_mux = exp_mux + 2'd1;
    check(nvalid == 1 && rises == 24, "R11 single frame", nvalid * 100 + rises, 124);
    check(cs_n_o && !busy_o, "R11 stays idle", {cs_n_o, busy_o}, 2);

    // R7 back to back.
    frame_w = {8'h00, 16'hC3A5};
    mon_clear();
    repeat_i = 1'b1;
    pulse_start();
    while (nvalid < 2) tick();
    repeat_i = 1'b0;
    wait_idle();
    exp_mux = exp_mux + 2'd2;
    check(last_gap == GP, "R7 chained gap", last_gap, GP);
    check(nvalid == 2 && rises == 48, "R7 two frames", nvalid * 100 + rises, 248);
    check(result_o == 16'hC3A5, "R7 chained result", int'(result_o), 'hC3A5);
    check(mux_sel_o == exp_mux, "R7 mux", int'(mux_sel_o), int'(exp_mux));

    // R8 pad errors: last pad bit, then a clean frame keeps the flag.
    run_frame(16'h8001, 8'h01, 1'b1);
    run_frame(16'h7FFE, 8'h00, 1'b1);
    run_frame(16'h0001, 8'h80, 1'b0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule